// File: doc/BRIEF.md
# Fractional I2C Bit-Clock Tick Generator

This block turns the module input clock into a one-cycle enable tick at twice the target I2C bit rate. A protocol engine uses each tick to advance one half of an SCL period, one for the low phase and one for the high phase. The divider is an accumulator. Every step it adds an increment and, on reaching a decrement threshold, subtracts that threshold and emits a tick. The long-run tick rate is therefore exactly increment/decrement per step, including ratios that are not integers.

Two divider settings are held, one for normal speed and one for high speed. A mode input picks between them, and that choice is captured only while the block is stopped. Both settings and the mode are frozen while the run enable is high, so a transfer never sees its bit timing change. An 8-bit module-clock divider thins the input clock into accumulator steps, and a value of zero turns the whole block off. A selected setting that cannot give a usable tick rate is flagged and produces no ticks.

Top module: `i2c_fracdiv_tick`

## Requirements
- R1: A configuration word carries the increment in bits [31:16] and the decrement in bits [15:0]. On a valid setting, the number of ticks after n accumulator steps from a cleared accumulator is exactly floor(n*inc/dec).
- R2: The tick is registered. With the accumulator starting at zero, the tick is high in the cycle that follows the step in which the running sum first reaches the decrement. For inc=1 and dec=10 with one step per cycle, that is the 10th cycle after the run enable rises.
- R3: `cfg_wr_norm` loads the normal-speed setting and `cfg_wr_fast` loads the high-speed setting. A captured mode of 0 selects the normal setting and a captured mode of 1 selects the high-speed setting.
- R4: Configuration writes that arrive while `run_en` is high are ignored and leave the tick sequence unchanged.
- R5: `speed_sel` is captured only while `run_en` is low. Changing it while running has no effect.
- R6: `cfg_bad` is high when the selected setting has a decrement of 6 or less, an increment of 0, or an increment not below the decrement. While it is high, no tick is produced. A decrement of 7 with an increment of 1 is valid.
- R7: A `gate_div` value of 0 disables the block: no ticks, and the accumulator is held at zero.
- R8: A `gate_div` value of D>0 makes the accumulator step once every D input cycles. The first step comes D cycles after the run enable rises, so no two ticks are adjacent when D>1.
- R9: With `run_en` low, the accumulator is cleared and the tick is low from the next cycle. A restart begins again from zero phase.
- R10: After reset the tick is low, both settings are zero (so `cfg_bad` is high), and the captured mode is normal speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run enable; high locks configuration and starts ticking |
| speed_sel | input | 1 | Setting select, 0 normal, 1 high speed; captured while stopped |
| gate_div | input | 8 | Module-clock divider; 0 disables, D steps the accumulator every D cycles |
| cfg_wr_norm | input | 1 | Write strobe for the normal-speed setting |
| cfg_wr_fast | input | 1 | Write strobe for the high-speed setting |
| cfg_wdata | input | 32 | Setting word: increment [31:16], decrement [15:0] |
| tick | output | 1 | One-cycle tick at twice the SCL rate |
| cfg_bad | output | 1 | Selected setting cannot produce a usable rate |

## Verification
The bench compares every cycle of each run window against a floor-based model of the tick position, so an accumulator that dropped its remainder on wrap would drift on non-integer ratios such as 3/20 or 1000/33333. A late or early first tick would show up as an off-by-one at the 10th cycle. A setting that leaked into a running divider, or a mode that switched mid-run, would change the tick spacing after the poke point. An accumulator that was not cleared on stop would put the first tick of a restart window too early. The validity boundary at decrement 6 versus 7 is probed, and so are the zero module-clock divider and a divider of 3. A block that ticked while disabled, or stepped at the wrong spacing, would fail those checks.

// File: rtl/i2c_fracdiv_pkg.sv
package i2c_fracdiv_pkg;

   typedef enum logic {
      SPD_NORMAL = 1'b0,
      SPD_FAST   = 1'b1
   } speed_e;

   localparam int unsigned NUM_BANK = 2;

endpackage

// File: rtl/fracdiv_cfg_bank.sv
module fracdiv_cfg_bank #(
   parameter int unsigned FIELD_W = 16,
   localparam int unsigned WORD_W = 2 * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lock,
   input  logic               wr,
   input  logic [WORD_W-1:0]  wdata,
   output logic [FIELD_W-1:0] inc_o,
   output logic [FIELD_W-1:0] dec_o
);

   logic [WORD_W-1:0] word_q;

   // R4: a locked bank ignores its write strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (wr && !lock) begin
         word_q <= wdata;
      end
   end

   // R1: increment in the upper half, decrement in the lower half
   assign inc_o = word_q[WORD_W-1:FIELD_W];
   assign dec_o = word_q[FIELD_W-1:0];

endmodule

// File: rtl/fracdiv_prescale.sv
module fracdiv_prescale #(
   parameter int unsigned GATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [GATE_W-1:0] div,
   output logic              gate_on_o,
   output logic              step_o
);

   localparam logic [GATE_W-1:0] ONE = GATE_W'(1);

   logic [GATE_W-1:0] cnt_q;
   logic              wrap;

   assign gate_on_o = (div != '0);
   assign wrap      = (cnt_q >= (div - ONE));
   assign step_o    = run && gate_on_o && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || !gate_on_o) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

endmodule

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
   parameter int unsigned FIELD_W = 16,
   localparam int unsigned SUM_W = FIELD_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               step,
   input  logic [FIELD_W-1:0] inc,
   input  logic [FIELD_W-1:0] dec,
   output logic               tick_o,
   output logic [FIELD_W-1:0] acc_o
);

   logic [FIELD_W-1:0] acc_q;
   logic [SUM_W-1:0]   sum;
   logic [SUM_W-1:0]   rem;
   logic               hit;

   assign sum = {1'b0, acc_q} + {1'b0, inc};
   assign hit = (sum >= {1'b0, dec});
   assign rem = sum - {1'b0, dec};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else if (!active) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else if (step) begin
         acc_q  <= hit ? rem[FIELD_W-1:0] : sum[FIELD_W-1:0];
         tick_o <= hit;
      end else begin
         tick_o <= 1'b0;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/i2c_fracdiv_tick.sv
module i2c_fracdiv_tick #(
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned GATE_W  = 8,
   parameter int unsigned MIN_DEC = 6,
   localparam int unsigned WORD_W = 2 * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              speed_sel,
   input  logic [GATE_W-1:0] gate_div,
   input  logic              cfg_wr_norm,
   input  logic              cfg_wr_fast,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic              tick,
   output logic              cfg_bad
);
   import i2c_fracdiv_pkg::*;

   initial begin : p_param_chk
      assert (FIELD_W >= 4) else $error("FIELD_W too small");
      assert (GATE_W >= 1) else $error("GATE_W must be positive");
      assert (MIN_DEC < (2 ** FIELD_W) - 1) else $error("MIN_DEC exceeds field");
   end

   logic [NUM_BANK-1:0]  bank_wr;
   logic [FIELD_W-1:0]   bank_inc [NUM_BANK];
   logic [FIELD_W-1:0]   bank_dec [NUM_BANK];
   speed_e               mode_q;
   logic [FIELD_W-1:0]   inc_sel;
   logic [FIELD_W-1:0]   dec_sel;
   logic                 gate_on;
   logic                 step;
   logic                 active;
   logic [FIELD_W-1:0]   acc;

   assign bank_wr[SPD_NORMAL] = cfg_wr_norm;
   assign bank_wr[SPD_FAST]   = cfg_wr_fast;

   // R3: one setting bank per speed
   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      fracdiv_cfg_bank #(.FIELD_W(FIELD_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .lock  (run_en),
         .wr    (bank_wr[b]),
         .wdata (cfg_wdata),
         .inc_o (bank_inc[b]),
         .dec_o (bank_dec[b])
      );
   end

   // R5: mode follows the select only while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SPD_NORMAL;
      end else if (!run_en) begin
         mode_q <= speed_e'(speed_sel);
      end
   end

   assign inc_sel = bank_inc[mode_q];
   assign dec_sel = bank_dec[mode_q];

   // R6: settings that cannot give a usable rate
   assign cfg_bad = (dec_sel <= FIELD_W'(MIN_DEC)) || (inc_sel == '0) ||
                    (inc_sel >= dec_sel);

   fracdiv_prescale #(.GATE_W(GATE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_en && !cfg_bad),
      .div       (gate_div),
      .gate_on_o (gate_on),
      .step_o    (step)
   );

   assign active = run_en && !cfg_bad && gate_on;

   fracdiv_accum #(.FIELD_W(FIELD_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .step   (step),
      .inc    (inc_sel),
      .dec    (dec_sel),
      .tick_o (tick),
      .acc_o  (acc)
   );

endmodule

// File: rtl/i2c_fracdiv_chk.sv
module i2c_fracdiv_chk #(
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned GATE_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run_en,
   input logic [GATE_W-1:0]  gate_div,
   input logic               tick,
   input logic               cfg_bad,
   input logic [FIELD_W-1:0] acc,
   input logic [FIELD_W-1:0] dec_sel,
   input logic [FIELD_W-1:0] inc_n,
   input logic [FIELD_W-1:0] dec_n,
   input logic [FIELD_W-1:0] inc_f,
   input logic [FIELD_W-1:0] dec_f,
   input logic               mode
);

   assert_acc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !cfg_bad) |-> (acc < dec_sel));

   assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> ($stable(inc_n) && $stable(dec_n) && $stable(inc_f) && $stable(dec_f)));

   assert_mode_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(mode));

   assert_bad_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |=> !tick);

   assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_div == '0) |=> (!tick && acc == '0));

   assert_gate_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gate_div > GATE_W'(1)) |=> !tick);

   assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!tick && acc == '0));

endmodule

bind i2c_fracdiv_tick i2c_fracdiv_chk #(.FIELD_W(FIELD_W), .GATE_W(GATE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .gate_div (gate_div),
   .tick     (tick),
   .cfg_bad  (cfg_bad),
   .acc      (acc),
   .dec_sel  (dec_sel),
   .inc_n    (bank_inc[0]),
   .dec_n    (bank_dec[0]),
   .inc_f    (bank_inc[1]),
   .dec_f    (bank_dec[1]),
   .mode     (mode_q)
);

// File: tb/i2c_fracdiv_tick_tb_top.sv
module i2c_fracdiv_tick_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        speed_sel = 1'b0;
   logic [7:0]  gate_div = 8'd1;
   logic        cfg_wr_norm = 1'b0;
   logic        cfg_wr_fast = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        tick;
   logic        cfg_bad;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   i2c_fracdiv_tick dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .speed_sel   (speed_sel),
      .gate_div    (gate_div),
      .cfg_wr_norm (cfg_wr_norm),
      .cfg_wr_fast (cfg_wr_fast),
      .cfg_wdata   (cfg_wdata),
      .tick        (tick),
      .cfg_bad     (cfg_bad)
   );

   task automatic check(string req, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit is_bad(longint inc, longint dec);
      return (dec <= 6) || (inc == 0) || (inc >= dec);
   endfunction

   // expected tick after the j-th cycle of a run window
   function automatic bit exp_tick(longint j, longint inc, longint dec, longint d);
      longint s;
      if (d == 0 || is_bad(inc, dec) || (j % d) != 0) return 1'b0;
      s = j / d;
      return ((s * inc) / dec) != (((s - 1) * inc) / dec);
   endfunction

   task automatic write_cfg(bit fast, int inc, int dec);
      @(negedge clk);
      cfg_wdata   = {inc[15:0], dec[15:0]};
      cfg_wr_norm = !fast;
      cfg_wr_fast = fast;
      @(negedge clk);
      cfg_wr_norm = 1'b0;
      cfg_wr_fast = 1'b0;
   endtask

   // runs m cycles, compares every tick to the model; poke_at>0 writes junk
   // to both banks and flips speed_sel at that cycle
   task automatic run_window(string req, int inc, int dec, int d, int m,
                             int poke_at, output int first, output int total);
      int bad_at = 0;
      bit exp_b;
      bit sel_keep;
      first = 0;
      total = 0;
      sel_keep = speed_sel;
      gate_div = 8'(d);
      @(negedge clk);
      run_en = 1'b1;
      for (int j = 1; j <= m; j++) begin
         @(negedge clk);
         cfg_wr_norm = 1'b0;
         cfg_wr_fast = 1'b0;
         exp_b = exp_tick(j, inc, dec, d);
         if (tick) begin
            total++;
            if (first == 0) first = j;
         end
         if (tick != exp_b && bad_at == 0) bad_at = j;
         if (j == poke_at) begin
            cfg_wdata   = 32'h0001_0009;
            cfg_wr_norm = 1'b1;
            cfg_wr_fast = 1'b1;
            speed_sel   = !speed_sel;
         end
      end
      check({req, " tick sequence first mismatch cycle"}, bad_at, 0);
      speed_sel = sel_keep;
      run_en = 1'b0;
      @(negedge clk);
      check("R9 tick low after stop", tick, 0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R10 tick in reset", tick, 0);
      check("R10 cfg_bad in reset", cfg_bad, 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 tick after reset", tick, 0);
      check("R10 zero settings flagged", cfg_bad, 1);
   endtask

   task automatic t_integer();
      int f, t;
      write_cfg(1'b0, 1, 10);
      check("R1 valid setting", cfg_bad, 0);
      run_window("R1", 1, 10, 1, 1000, 0, f, t);
      check("R1 tick count 1/10", t, 100);
      check("R2 first tick cycle", f, 10);
   endtask

   task automatic t_fraction();
      int f, t;
      write_cfg(1'b0, 3, 20);
      run_window("R1 3/20", 3, 20, 1, 1001, 0, f, t);
      check("R1 tick count 3/20", t, 150);
      write_cfg(1'b0, 7, 9);
      run_window("R1 7/9", 7, 9, 1, 900, 0, f, t);
      check("R1 tick count 7/9", t, 700);
      write_cfg(1'b0, 1000, 33333);
      run_window("R1 1000/33333", 1000, 33333, 1, 3000, 0, f, t);
      check("R1 tick count 1000/33333", t, 90);
   endtask

   task automatic t_fast_bank();
      int f, t;
      write_cfg(1'b0, 1, 10);
      write_cfg(1'b1, 1, 8);
      speed_sel = 1'b1;
      @(negedge clk);
      run_window("R3 fast bank", 1, 8, 1, 800, 0, f, t);
      check("R3 fast bank count", t, 100);
      speed_sel = 1'b0;
      @(negedge clk);
      run_window("R3 normal bank", 1, 10, 1, 500, 0, f, t);
      check("R3 normal bank count", t, 50);
   endtask

   task automatic t_lock();
      int f, t;
      write_cfg(1'b0, 2, 25);
      run_window("R4 R5 poke while running", 2, 25, 1, 1000, 300, f, t);
      check("R4 count unchanged by write", t, 80);
      check("R5 mode kept normal", cfg_bad, 0);
      run_window("R4 setting kept after poke", 2, 25, 1, 250, 0, f, t);
      check("R4 setting still 2/25", t, 20);
   endtask

   task automatic t_invalid();
      int f, t;
      write_cfg(1'b0, 1, 6);
      check("R6 dec 6 flagged", cfg_bad, 1);
      run_window("R6 dec 6 quiet", 1, 6, 1, 100, 0, f, t);
      check("R6 no ticks dec 6", t, 0);
      write_cfg(1'b0, 1, 7);
      check("R6 dec 7 accepted", cfg_bad, 0);
      run_window("R6 dec 7", 1, 7, 1, 140, 0, f, t);
      check("R6 dec 7 count", t, 20);
      write_cfg(1'b0, 0, 50);
      check("R6 inc 0 flagged", cfg_bad, 1);
      write_cfg(1'b0, 50, 50);
      check("R6 inc equal dec flagged", cfg_bad, 1);
      run_window("R6 inc==dec quiet", 50, 50, 1, 100, 0, f, t);
      check("R6 no ticks inc==dec", t, 0);
   endtask

   task automatic t_gate();
      int f, t;
      write_cfg(1'b0, 1, 7);
      run_window("R7 gate zero", 1, 7, 0, 200, 0, f, t);
      check("R7 no ticks with gate 0", t, 0);
      run_window("R8 gate 3", 1, 7, 3, 420, 0, f, t);
      check("R8 gate 3 count", t, 20);
      check("R8 gate 3 first tick", f, 21);
      gate_div = 8'd1;
   endtask

   task automatic t_restart();
      int f, t;
      write_cfg(1'b0, 1, 10);
      run_window("R9 partial", 1, 10, 1, 6, 0, f, t);
      check("R9 partial no tick", t, 0);
      run_window("R9 restart", 1, 10, 1, 30, 0, f, t);
      check("R9 restart first tick from zero phase", f, 10);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      t_integer();
      t_fraction();
      t_fast_bank();
      t_lock();
      t_invalid();
      t_gate();
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule